// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the front end of a configuration space that software reaches through two byte-wide I/O locations: an index port at a strapped base address and a data port one address above it. The space stays closed until software writes the enter key byte to the index port twice in a row. While the space is open, an index-port write latches a register index, and a data-port access reads or writes the register that index selects. A separate exit key written to the index port closes the space again.

Indices below a fixed floor are global registers held in this block. One of them selects the active logical device, and another returns a read-only chip identity byte. Indices at or above the floor are passed to the downstream logical devices as a one-cycle read or write strobe. Each strobe carries the selected device number, the index and the write byte. The downstream read byte is returned on the data port in the same cycle. A read-modify-write is done by latching the index, reading the data port, latching the index again and then writing the data port.

The key sequence is tracked by a three-state machine. The states are LOCKED, HALF (one enter key seen) and OPEN. The transitions are: LOCKED to HALF on an enter key at the index port. HALF to OPEN on a second enter key. HALF to LOCKED on any other write to either port. OPEN to LOCKED on the exit key. Every other write leaves the state unchanged.

Top module: `cfg_port_unlock`

## Requirements
- R1: Two consecutive writes of 0x87 to the index port open the space, and `cfg_open` is high from the clock edge that takes the second write.
- R2: A write to either port between the two enter keys, other than 0x87 to the index port, returns the sequence to LOCKED, so that a fresh pair of 0x87 writes is needed.
- R3: While open, a write of 0xAA to the index port closes the space and leaves the latched index unchanged.
- R4: With `strap_alt_base` low, the index port is at 0x2E and the data port at 0x2F. With it high, they are at 0x4E and 0x4F. Accesses at any other address change nothing and read 0xFF.
- R5: While the space is not open, writes other than the key bytes leave the index and the registers unchanged, no device strobe is raised, and reads of either port return 0xFF.
- R6: While open, an index-port write of any byte other than 0xAA latches that byte as the index, and an index-port read returns the latched index.
- R7: Global index 0x07 is the logical-device select. A data write stores the byte on `ld_sel`, and a data read returns it.
- R8: Global index 0x20 reads the `CHIP_ID` parameter, and data writes to it are ignored.
- R9: Every other global index below 0x30 reads 0x00, and data writes to it are ignored.
- R10: For an index of 0x30 or above, a data-port write raises `dev_wr` during that access and a data-port read raises `dev_rd` during that access. Each strobe carries `dev_num` equal to `ld_sel`, `dev_idx` equal to the index and `dev_wdata` equal to the written byte. A forwarded read returns `dev_rdata` on `io_rdata`.
- R11: After reset the space is LOCKED, and the index and `ld_sel` are both 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_alt_base | input | 1 | Base select: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid while io_rd is high |
| cfg_open | output | 1 | Configuration space open |
| ld_sel | output | 8 | Selected logical device number |
| dev_wr | output | 1 | Forwarded write strobe |
| dev_rd | output | 1 | Forwarded read strobe |
| dev_num | output | 8 | Logical device addressed by the strobe |
| dev_idx | output | 8 | Register index addressed by the strobe |
| dev_wdata | output | 8 | Forwarded write byte |
| dev_rdata | input | 8 | Read byte returned by the addressed device |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, bases 0x2E and 0x4E, and chip ID 0x5C. With an 8-bit key and an 8-bit index, this lets it sweep every possible second key byte and every index in the open state. Each read result is predicted arithmetically, because the bench returns a device byte that is a fixed XOR of index and device number. Both strap settings are driven, and the interleaving cases of the key sequence are covered alongside the full sweeps.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } cfg_state_e;

    localparam int          BYTE_W        = 8;
    localparam logic [7:0]  KEY_ENTER     = 8'h87;
    localparam logic [7:0]  KEY_EXIT      = 8'hAA;
    localparam logic [7:0]  IDX_LDSEL     = 8'h07;
    localparam logic [7:0]  IDX_CHIPID    = 8'h20;
    localparam logic [7:0]  IDX_FWD_FLOOR = 8'h30;
    localparam logic [7:0]  BYTE_IDLE     = 8'hFF;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              cfg_open,
    output logic              exit_hit
);
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wbyte == KEY_ENTER) state_d = ST_HALF;
            ST_HALF: begin
                if (idx_wr && wbyte == KEY_ENTER) state_d = ST_OPEN;
                else if (idx_wr || dat_wr)        state_d = ST_LOCKED;
            end
            ST_OPEN:   if (idx_wr && wbyte == KEY_EXIT) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_open = (state_q == ST_OPEN);
        exit_hit = (state_q == ST_OPEN) && idx_wr && (wbyte == KEY_EXIT);
    end

    // R1: OPEN is only ever entered from HALF on a second enter key
    a_r1_open_after_two_keys: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && wbyte == KEY_ENTER && state_q == ST_HALF) |=> (state_q == ST_OPEN));
    a_r1_open_entry_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OPEN) |=> (state_q != ST_OPEN || $past(state_q) == ST_HALF));
    // R2: a stray write between the keys drops the sequence
    a_r2_stray_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALF && dat_wr && !idx_wr) |=> (state_q == ST_LOCKED));
    // R3: the exit key closes the space
    a_r3_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && idx_wr && wbyte == KEY_EXIT) |=> (state_q == ST_LOCKED));
endmodule

// File: rtl/cfgp_reg_decode.sv
module cfgp_reg_decode
    import cfgp_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_open,
    input  logic              exit_hit,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic              idx_rd,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] ld_sel,
    output logic [BYTE_W-1:0] idx_out,
    output logic              dev_wr,
    output logic              dev_rd
);
    logic [BYTE_W-1:0] idx_q;
    logic [BYTE_W-1:0] ld_q;
    logic              fwd;

    assign fwd = (idx_q >= IDX_FWD_FLOOR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ld_q  <= '0;
        end else begin
            if (cfg_open && idx_wr && !exit_hit) idx_q <= wbyte;
            if (cfg_open && dat_wr && idx_q == IDX_LDSEL) ld_q <= wbyte;
        end
    end

    always_comb begin
        dev_wr = cfg_open && dat_wr && fwd;
        dev_rd = cfg_open && dat_rd && fwd;
        rdata  = BYTE_IDLE;
        if (cfg_open && idx_rd) begin
            rdata = idx_q;
        end else if (cfg_open && dat_rd) begin
            if (fwd) rdata = dev_rdata;
            else if (idx_q == IDX_LDSEL)  rdata = ld_q;
            else if (idx_q == IDX_CHIPID) rdata = CHIP_ID;
            else rdata = '0;
        end
    end

    assign ld_sel  = ld_q;
    assign idx_out = idx_q;

    // R5/R3: index changes only through an accepted index write while open
    a_r5_idx_held_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open || exit_hit) |=> $stable(idx_q));
    // R7: the device select takes the written byte
    a_r7_ldsel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && dat_wr && idx_q == IDX_LDSEL) |=> (ld_q == $past(wbyte)));
    // R8/R9: global writes elsewhere leave the select alone
    a_r9_ldsel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_open && dat_wr && idx_q == IDX_LDSEL)) |=> $stable(ld_q));
endmodule

// File: rtl/cfg_port_unlock.sv
module cfg_port_unlock
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_PRI  = 16'h002E,
    parameter logic [15:0] BASE_ALT  = 16'h004E,
    parameter logic [7:0]  CHIP_ID   = 8'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [7:0]        ld_sel,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [7:0]        dev_num,
    output logic [7:0]        dev_idx,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata
);
    localparam logic [ADDR_W-1:0] IDX_PRI = ADDR_W'(BASE_PRI);
    localparam logic [ADDR_W-1:0] IDX_ALT = ADDR_W'(BASE_ALT);

    logic [ADDR_W-1:0] idx_addr, dat_addr;
    logic hit_idx, hit_dat, idx_wr, dat_wr, idx_rd, dat_rd, exit_hit;

    assign idx_addr = strap_alt_base ? IDX_ALT : IDX_PRI;
    assign dat_addr = idx_addr + ADDR_W'(1);
    assign hit_idx  = (io_addr == idx_addr);
    assign hit_dat  = (io_addr == dat_addr);
    assign idx_wr   = io_wr && hit_idx;
    assign dat_wr   = io_wr && hit_dat;
    assign idx_rd   = io_rd && hit_idx;
    assign dat_rd   = io_rd && hit_dat;

    cfgp_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wbyte    (io_wdata),
        .cfg_open (cfg_open),
        .exit_hit (exit_hit)
    );

    cfgp_reg_decode #(.CHIP_ID(CHIP_ID)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_open  (cfg_open),
        .exit_hit  (exit_hit),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .idx_rd    (idx_rd),
        .dat_rd    (dat_rd),
        .wbyte     (io_wdata),
        .dev_rdata (dev_rdata),
        .rdata     (io_rdata),
        .ld_sel    (ld_sel),
        .idx_out   (dev_idx),
        .dev_wr    (dev_wr),
        .dev_rd    (dev_rd)
    );

    assign dev_num   = ld_sel;
    assign dev_wdata = io_wdata;

    // R5: nothing reaches the devices while closed
    a_r5_no_strobe_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> (!dev_wr && !dev_rd));
    a_r5_idle_read_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |-> (io_rdata == BYTE_IDLE));
    // R10: forwarded strobes only for indices at or above the floor
    a_r10_fwd_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> (dev_idx >= IDX_FWD_FLOOR && (io_wr || io_rd)));
endmodule

// File: tb/cfg_port_unlock_tb.sv
module cfg_port_unlock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt_base = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata, ld_sel, dev_num, dev_idx, dev_wdata, dev_rdata;
    logic        cfg_open, dev_wr, dev_rd;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] base = 16'h002E;
    logic        cap_wr, cap_rd;
    logic [7:0]  cap_num, cap_idx, cap_wd, rb;

    localparam logic [7:0] CHIP = 8'h5C;

    always #5 clk = ~clk;

    assign dev_rdata = dev_idx ^ dev_num ^ 8'h3C;

    cfg_port_unlock dut_i (
        .clk(clk), .rst_n(rst_n), .strap_alt_base(strap_alt_base),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cfg_open(cfg_open), .ld_sel(ld_sel),
        .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_num(dev_num), .dev_idx(dev_idx),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        #1;
        cap_wr = dev_wr; cap_rd = dev_rd; cap_num = dev_num; cap_idx = dev_idx; cap_wd = dev_wdata;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        rb = io_rdata; cap_wr = dev_wr; cap_rd = dev_rd; cap_num = dev_num; cap_idx = dev_idx;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(base, 8'h87); wr(base, 8'h87);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check(cfg_open == 1'b0, "R11 open after reset", cfg_open, 0);
        check(ld_sel == 8'h00, "R11 ld_sel after reset", ld_sel, 0);
        // R5 locked behaviour
        rd(base);     check(rb == 8'hFF, "R5 locked index read", rb, 8'hFF);
        rd(base + 1); check(rb == 8'hFF, "R5 locked data read", rb, 8'hFF);
        wr(base, 8'h40);
        wr(base + 1, 8'h55);
        check(!cap_wr && !cap_rd, "R5 locked strobe", cap_wr, 0);
        check(cfg_open == 1'b0, "R5 still locked", cfg_open, 0);
        unlock();
        rd(base); check(rb == 8'h00, "R11 R5 index zero", rb, 8'h00);
        wr(base, 8'hAA);

        // R1 R2 sweep of second key byte
        for (int b = 0; b < 256; b++) begin
            wr(base, 8'h87); wr(base, 8'(b));
            #1;
            check(cfg_open == (b == 8'h87), $sformatf("R1 R2 second byte %0h", b), cfg_open, b == 8'h87);
            if (cfg_open) wr(base, 8'hAA);
        end
        // R2 data-port write between keys
        wr(base, 8'h87); wr(base + 1, 8'h87); wr(base, 8'h87);
        #1; check(cfg_open == 1'b0, "R2 data write between keys", cfg_open, 0);
        wr(base, 8'h00);
        wr(base, 8'h87); #1;
        check(cfg_open == 1'b0, "R2 single key not open", cfg_open, 0);
        wr(base, 8'h87); #1;
        check(cfg_open == 1'b1, "R1 fresh pair opens", cfg_open, 1);
        wr(base, 8'hAA);

        // R4 strap
        strap_alt_base = 1'b1; base = 16'h004E;
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h87); #1;
        check(cfg_open == 1'b0, "R4 old base ignored", cfg_open, 0);
        unlock(); #1;
        check(cfg_open == 1'b1, "R4 alt base opens", cfg_open, 1);
        wr(base, 8'h20); rd(base + 1);
        check(rb == CHIP, "R4 R8 alt data port", rb, CHIP);
        rd(16'h002F); check(rb == 8'hFF, "R4 other address reads idle", rb, 8'hFF);
        wr(base, 8'hAA);
        strap_alt_base = 1'b0; base = 16'h002E;
        unlock();

        // R7 select writes
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'h08 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h5A;
            wr(base, 8'h07); wr(base + 1, v);
            check(ld_sel == v, "R7 ld_sel output", ld_sel, v);
            rd(base + 1); check(rb == v, "R7 ld_sel readback", rb, v);
        end
        wr(base, 8'h07); wr(base + 1, 8'h08);

        // R6 R8 R9 R10 R3 index sweep with reads
        for (int i = 0; i < 256; i++) begin
            logic [7:0] e;
            wr(base, 8'(i));
            if (i == 8'hAA) begin
                #1; check(cfg_open == 1'b0, "R3 exit key in sweep", cfg_open, 0);
                unlock();
                rd(base); check(rb == 8'hA9, "R3 index kept on exit", rb, 8'hA9);
            end else begin
                rd(base); check(rb == 8'(i), "R6 index readback", rb, i);
                rd(base + 1);
                if (i >= 8'h30)      e = 8'(i) ^ 8'h08 ^ 8'h3C;
                else if (i == 8'h07) e = 8'h08;
                else if (i == 8'h20) e = CHIP;
                else                 e = 8'h00;
                check(rb == e, $sformatf("R8 R9 R10 data read idx %0h", i), rb, e);
                check(cap_rd == (i >= 8'h30), "R10 dev_rd strobe", cap_rd, i >= 8'h30);
                if (i >= 8'h30)
                    check(cap_idx == 8'(i) && cap_num == 8'h08, "R10 read index/num", cap_idx, i);
            end
        end

        // R10 forwarded writes
        for (int i = 8'h30; i < 256; i += 7) begin
            if (i == 8'hAA) continue;
            wr(base, 8'(i)); wr(base + 1, 8'(i) ^ 8'hC3);
            check(cap_wr && cap_idx == 8'(i) && cap_num == 8'h08 && cap_wd == (8'(i) ^ 8'hC3),
                  "R10 forwarded write", {cap_wr, cap_idx}, {1'b1, 8'(i)});
        end
        // R8 R9 ignored writes
        wr(base, 8'h20); wr(base + 1, 8'h11); rd(base + 1);
        check(rb == CHIP, "R8 chip id write ignored", rb, CHIP);
        check(!cap_wr, "R8 no strobe", cap_wr, 0);
        wr(base, 8'h10); wr(base + 1, 8'h77); rd(base + 1);
        check(rb == 8'h00, "R9 global write ignored", rb, 0);
        wr(base, 8'h07); rd(base + 1);
        check(rb == 8'h08, "R9 select untouched", rb, 8'h08);
        // R3 exit keeps index
        wr(base, 8'h45); wr(base, 8'hAA); #1;
        check(cfg_open == 1'b0, "R3 exit closes", cfg_open, 0);
        wr(base + 1, 8'h99);
        check(!cap_wr, "R5 no strobe after exit", cap_wr, 0);
        unlock(); rd(base);
        check(rb == 8'h45, "R3 index after exit", rb, 8'h45);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule